// File: doc/BRIEF.md
# Page Write Collector with Top-Quarter Guard

This block sits between the serial protocol engine of a byte-addressed non-volatile memory and its storage array. While a write command is in flight it gathers the incoming data bytes into a one-row staging latch. Every latch slot has a valid flag, so that only bytes that were actually received are later programmed. It watches the write-control input during the command header and uses it to decide whether the top quarter of the array may be changed. When the protocol engine reports a STOP that falls directly after an acknowledge, the block runs a self-timed write cycle. During that cycle it reports busy, replays the staged bytes to the array write port one per clock, and ignores the bus.

The protocol engine gives the block a set of single-cycle pulses. One marks the START of a command. One marks the end of the two address bytes, together with the 13-bit start address. One marks each received data byte. Two more mark the STOP: one when it falls in the slot after an acknowledge, one when it falls anywhere else. For each data byte the block returns a one-cycle acknowledge enable. The length of the write cycle is a parameter counted in system clocks, so a test setup can use a short cycle and silicon can use about 10 ms.

Top module: `pwb_top`

## Requirements
- R1: A START clears every staged byte. A committed cycle writes only row positions that received a data byte after the most recent START, and it issues no write at all for the other positions.
- R2: Data bytes go to consecutive positions in the row, starting at the low PAGE_W bits of the start address. The upper address bits (the row) stay the same for every byte of a command.
- R3: After position ROW_BYTES-1, the next byte goes to position 0 of the same row. When more than ROW_BYTES bytes arrive, the position holds the last byte sent to it, and at most ROW_BYTES writes are issued.
- R4: If the write-control input is high in any clock from the START pulse up to and including the address-complete pulse, and the row lies in the top quarter (the two most significant address bits are both 1), then the cycle writes nothing. A high level in that window has no effect on rows outside the top quarter.
- R5: A high write-control level that appears only after the address-complete pulse does not block writes, even to the top quarter.
- R6: The acknowledge enable is high for exactly the one clock after a data-byte pulse, and only when the write-control input was low at that pulse.
- R7: A STOP-after-acknowledge with at least one data byte received raises busy in the next clock. Busy then stays high for exactly CYCLE_CLKS clocks.
- R8: A STOP in any other slot, or a STOP-after-acknowledge with no data byte received, discards the command. Busy stays low and nothing is written.
- R9: While busy, the START, address, data and STOP pulses are ignored. They cause no acknowledge, no extra write and no change to the cycle length.
- R10: After reset, busy, the acknowledge enable and the write strobe are low. Array writes happen only while busy, at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | START of a command seen on the bus (pulse) |
| addr_valid | input | 1 | Both address bytes received (pulse) |
| addr_in | input | ADDR_W | Start address, valid with addr_valid |
| data_stb | input | 1 | Data byte received (pulse) |
| data_in | input | 8 | Data byte, valid with data_stb |
| wc | input | 1 | Write-control level; high protects the top quarter |
| stop_ack | input | 1 | STOP in the slot after an acknowledge (pulse) |
| stop_other | input | 1 | STOP in any other slot (pulse) |
| ack_ok | output | 1 | Acknowledge enable for the byte strobed one clock earlier |
| busy | output | 1 | Write cycle in progress |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | ADDR_W | Array write address |
| wr_data | output | 8 | Array write data |

## Verification
The bench runs a small array of eight rows. It sends write commands whose start positions sit mid-row, near the end of the row, and at position 0 with more than a full row of data. These patterns separate a plain increment from a wrap within the row, and they show whether the last byte wins when a position is written twice. The write-control input is raised in one chosen clock of the header: at START, in the gap, or at the address pulse. It is also raised only during the data phase, and it is used on both top-quarter and lower rows. These cases show whether the protection window is sampled in full, whether it closes at the right clock, and whether the row decode is correct. Discarded STOPs, restarted commands and pulses injected during busy show that stale or late input never reaches the array. After each command the bench compares the whole array against a model it computes for itself.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_BUSY = 2'd3
    } phase_t;

    typedef struct packed {
        logic  keep;
        byte_t data;
    } slot_t;

    // Top quarter of the array: both row MSBs set.
    function automatic logic in_top_quarter(input logic [1:0] msbs);
        return &msbs;
    endfunction
endpackage

// File: rtl/pwb_guard.sv
module pwb_guard (
    input  logic clk,
    input  logic rst,
    input  logic open_win,
    input  logic close_win,
    input  logic wc,
    output logic prot
);
    logic window_q;
    logic prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            window_q <= 1'b0;
            prot_q   <= 1'b0;
        end else if (open_win) begin
            window_q <= 1'b1;
            prot_q   <= wc;
        end else if (window_q) begin
            prot_q <= prot_q | wc;
            if (close_win) window_q <= 1'b0;
        end
    end

    assign prot = prot_q;

    assert_window_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (window_q && wc && !open_win) |=> prot_q);
endmodule

// File: rtl/pwb_row_latch.sv
module pwb_row_latch #(
    parameter int PAGE_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                wr,
    input  logic [PAGE_W-1:0]   wr_slot,
    input  pwb_pkg::slot_t      wr_val,
    input  logic [PAGE_W-1:0]   rd_slot,
    output logic                rd_valid,
    output pwb_pkg::byte_t      rd_data
);
    localparam int ROW_BYTES = 1 << PAGE_W;

    logic           valid_q [ROW_BYTES];
    pwb_pkg::byte_t data_q  [ROW_BYTES];

    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                valid_q[g] <= 1'b0;
            end else if (wr && wr_slot == PAGE_W'(g)) begin
                valid_q[g] <= wr_val.keep;
            end
        end
        always_ff @(posedge clk) begin
            if (wr && wr_slot == PAGE_W'(g)) data_q[g] <= wr_val.data;
        end
    end

    assign rd_valid = valid_q[rd_slot];
    assign rd_data  = data_q[rd_slot];
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit #(
    parameter int PAGE_W     = 5,
    parameter int CYCLE_CLKS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              busy,
    output logic              scan_on,
    output logic [PAGE_W-1:0] scan_slot,
    output logic              done
);
    localparam int ROW_BYTES = 1 << PAGE_W;
    localparam int TCNT_W    = $clog2(CYCLE_CLKS + 1);

    logic              busy_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [PAGE_W:0]   sidx_q;

    assign done      = busy_q && (tcnt_q == TCNT_W'(CYCLE_CLKS - 1));
    assign scan_on   = busy_q && (sidx_q < (PAGE_W+1)'(ROW_BYTES));
    assign scan_slot = sidx_q[PAGE_W-1:0];
    assign busy      = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tcnt_q <= '0;
            sidx_q <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q <= 1'b1;
                tcnt_q <= '0;
                sidx_q <= '0;
            end
        end else begin
            tcnt_q <= tcnt_q + 1'b1;
            if (scan_on) sidx_q <= sidx_q + 1'b1;
            if (done) busy_q <= 1'b0;
        end
    end

    assert_scan_in_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        scan_on |-> busy_q);
    assert_scan_done_first_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !scan_on);
endmodule

// File: rtl/pwb_top.sv
module pwb_top #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_W     = 5,
    parameter int CYCLE_CLKS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_stb,
    input  logic [7:0]        data_in,
    input  logic              wc,
    input  logic              stop_ack,
    input  logic              stop_other,
    output logic              ack_ok,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    import pwb_pkg::*;

    localparam int ROW_W = ADDR_W - PAGE_W;

    phase_t            phase_q;
    logic [ROW_W-1:0]  row_q;
    logic [PAGE_W-1:0] ptr_q;
    logic              got_q;
    logic              ack_q;

    logic              prot;
    logic              busy_i;
    logic              scan_on;
    logic [PAGE_W-1:0] scan_slot;
    logic              done;
    logic              rd_valid;
    byte_t             rd_data;

    logic   take_start, take_addr, take_byte, go, clr;
    slot_t  wr_val;

    assign take_start = cmd_start && (phase_q != PH_BUSY);
    assign take_addr  = (phase_q == PH_ADDR) && addr_valid && !cmd_start
                        && !stop_ack && !stop_other;
    assign take_byte  = (phase_q == PH_DATA) && data_stb && !cmd_start
                        && !stop_ack && !stop_other;
    assign go         = (phase_q == PH_DATA) && !cmd_start && stop_ack && got_q;
    assign clr        = take_start || done;

    assign wr_val.keep = !(prot && in_top_quarter(row_q[ROW_W-1 -: 2]));
    assign wr_val.data = data_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            row_q   <= '0;
            ptr_q   <= '0;
            got_q   <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= take_byte && !wc;
            unique case (phase_q)
                PH_IDLE: if (cmd_start) phase_q <= PH_ADDR;
                PH_ADDR: begin
                    if (cmd_start)                    phase_q <= PH_ADDR;
                    else if (stop_ack || stop_other)  phase_q <= PH_IDLE;
                    else if (addr_valid) begin
                        row_q   <= addr_in[ADDR_W-1:PAGE_W];
                        ptr_q   <= addr_in[PAGE_W-1:0];
                        got_q   <= 1'b0;
                        phase_q <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (cmd_start)      phase_q <= PH_ADDR;
                    else if (stop_ack)  phase_q <= got_q ? PH_BUSY : PH_IDLE;
                    else if (stop_other) phase_q <= PH_IDLE;
                    else if (data_stb) begin
                        ptr_q <= ptr_q + 1'b1;   // wraps inside the row
                        got_q <= 1'b1;
                    end
                end
                PH_BUSY: if (done) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    pwb_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .open_win  (take_start),
        .close_win (take_addr),
        .wc        (wc),
        .prot      (prot)
    );

    pwb_row_latch #(.PAGE_W(PAGE_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wr       (take_byte),
        .wr_slot  (ptr_q),
        .wr_val   (wr_val),
        .rd_slot  (scan_slot),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    pwb_commit #(.PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)) u_commit (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .busy      (busy_i),
        .scan_on   (scan_on),
        .scan_slot (scan_slot),
        .done      (done)
    );

    assign busy    = busy_i;
    assign ack_ok  = ack_q;
    assign wr_en   = scan_on && rd_valid;
    assign wr_addr = {row_q, scan_slot};
    assign wr_data = rd_data;

    assert_write_only_busy_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);
    assert_busy_from_stop_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_ack));
    assert_no_ack_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (data_stb && busy) |=> !ack_ok);
    assert_no_ack_wc_high_R6: assert property (@(posedge clk) disable iff (rst)
        (data_stb && wc) |=> !ack_ok);
    assert_discard_no_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (stop_other && !busy) |=> !busy);
    assert_protected_row_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && prot) |-> !in_top_quarter(wr_addr[ADDR_W-1 -: 2]));
endmodule

// File: tb/pwb_top_test.sv
module pwb_top_test;
    localparam int CLK_PER = 10;
    localparam int AW      = 8;
    localparam int PW      = 5;
    localparam int CYC     = 40;
    localparam int RB      = 1 << PW;
    localparam int MEMSZ   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 0, addr_valid = 0, data_stb = 0, wc = 0;
    logic          stop_ack = 0, stop_other = 0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    data_in = '0;
    logic          ack_ok, busy, wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    int nchk = 0, nfail = 0, wcount = 0;
    bit finished = 0;
    logic [7:0] mem [MEMSZ];
    logic [7:0] exp_m [MEMSZ];

    always #(CLK_PER/2) clk = ~clk;

    pwb_top #(.ADDR_W(AW), .PAGE_W(PW), .CYCLE_CLKS(CYC)) uut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .addr_valid(addr_valid),
        .addr_in(addr_in), .data_stb(data_stb), .data_in(data_in), .wc(wc),
        .stop_ack(stop_ack), .stop_other(stop_other), .ack_ok(ack_ok),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // array model fed from the write port; R10 writes only while busy
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            mem[wr_addr] = wr_data;
            wcount++;
            chk(busy, "R10 write outside cycle", 0, 1);
        end
    end

    function automatic logic [7:0] dval(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 1) & 255);
    endfunction

    // stop_kind: 0 = after ack, 1 = elsewhere
    task automatic run_cmd(input string req, input int a, input int n,
                           input bit w0, input bit w1, input bit w2, input bit wd,
                           input int stop_kind, input bit junk, input bit interfere,
                           input int seed);
        bit blocked, commit;
        int cnt, expw, pos, lim;
        blocked = (w0 | w1 | w2) && (a[7:6] == 2'b11);
        commit  = (stop_kind == 0) && (n > 0);
        wcount  = 0;
        if (junk) begin   // partial command that a restart must discard (R1)
            @(negedge clk); cmd_start = 1;
            @(negedge clk); cmd_start = 0; addr_valid = 1; addr_in = AW'(a ^ 8'h11);
            @(negedge clk); addr_valid = 0; data_stb = 1; data_in = 8'h5A;
            @(negedge clk); data_in = 8'hA5;
            @(negedge clk); data_stb = 0;
        end
        @(negedge clk); cmd_start = 1; wc = w0;
        @(negedge clk); cmd_start = 0; wc = w1;
        @(negedge clk); addr_valid = 1; addr_in = AW'(a); wc = w2;
        @(negedge clk); addr_valid = 0; wc = wd;
        for (int i = 0; i < n; i++) begin
            data_stb = 1; data_in = dval(seed, i);
            @(negedge clk); data_stb = 0;
            chk(ack_ok == !wd, "R6 ack enable", ack_ok, !wd);
        end
        @(negedge clk);
        chk(ack_ok == 0, "R6 ack one clock only", ack_ok, 0);
        if (stop_kind == 0) stop_ack = 1; else stop_other = 1;
        @(negedge clk); stop_ack = 0; stop_other = 0; wc = 0;
        if (commit) begin
            cnt = 0;
            while (busy && cnt < 4 * CYC) begin
                cnt++;
                if (interfere) begin
                    if (cnt == 3) begin cmd_start = 1; addr_valid = 1; addr_in = 8'h00; end
                    if (cnt == 4) begin cmd_start = 0; addr_valid = 0; data_stb = 1; data_in = 8'h77; end
                    if (cnt == 5) begin
                        data_stb = 0;
                        chk(ack_ok == 0, "R9 ack while busy", ack_ok, 0);
                    end
                    if (cnt == 6) stop_ack = 1;
                    if (cnt == 7) stop_ack = 0;
                end
                @(negedge clk);
            end
            chk(cnt == CYC, {req, " R7 cycle length"}, cnt, CYC);
            @(negedge clk);
            chk(busy == 0, "R9 no second cycle", busy, 0);
        end else begin
            repeat (3) begin
                chk(busy == 0, "R8 discard keeps idle", busy, 0);
                @(negedge clk);
            end
        end
        expw = 0;
        if (commit && !blocked) begin
            lim = (n < RB) ? n : RB;
            expw = lim;
            for (int i = 0; i < n; i++) begin
                pos = ((a % RB) + i) % RB;
                exp_m[(a / RB) * RB + pos] = dval(seed, i);
            end
        end
        chk(wcount == expw, {req, " write count"}, wcount, expw);
        for (int k = 0; k < MEMSZ; k++)
            chk(mem[k] === exp_m[k], {req, " array byte"}, int'(mem[k]), int'(exp_m[k]));
    endtask

    initial begin
        for (int k = 0; k < MEMSZ; k++) begin mem[k] = 8'hFF; exp_m[k] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && ack_ok == 0 && wr_en == 0, "R10 reset state",
            {busy, ack_ok, wr_en}, 0);
        run_cmd("R2",  8'h05, 3,  0,0,0,0, 0, 0, 0, 1);  // mid-row start
        run_cmd("R3",  8'h3C, 6,  0,0,0,0, 0, 0, 0, 2);  // wraps 28..31,0,1
        run_cmd("R3",  8'h40, 34, 0,0,0,0, 0, 0, 0, 3);  // overfull row, last wins
        run_cmd("R4",  8'hC3, 4,  0,1,0,0, 0, 0, 0, 4);  // wc in gap, top row
        run_cmd("R4",  8'hE0, 2,  0,0,1,0, 0, 0, 0, 5);  // wc at address pulse
        run_cmd("R4",  8'hF0, 2,  1,0,0,0, 0, 0, 0, 6);  // wc at START
        run_cmd("R4",  8'h20, 3,  1,1,1,0, 0, 0, 0, 7);  // lower row unaffected
        run_cmd("R5",  8'hD0, 5,  0,0,0,1, 0, 0, 0, 8);  // wc only in data phase
        run_cmd("R2",  8'hFE, 3,  0,0,0,0, 0, 0, 0, 9);  // top row, wc low, wraps
        run_cmd("R8",  8'h60, 2,  0,0,0,0, 1, 0, 0, 10); // stop elsewhere
        run_cmd("R8",  8'h70, 0,  0,0,0,0, 0, 0, 0, 11); // stop with no data
        run_cmd("R9",  8'h88, 4,  0,0,0,0, 0, 0, 1, 12); // pulses during busy
        run_cmd("R1",  8'hA8, 1,  0,0,0,0, 0, 1, 0, 13); // restart drops old bytes
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule